// File: doc/BRIEF.md
# Serial NOR Flash Target Model

This block behaves as the memory side of a serial NOR flash on a chip-select, serial-clock and four-line data bus. It takes a one-byte command on a single line and then an address of three or four bytes, sent on one line or on four. Fast reads then skip a fixed run of dummy clocks. After that the block either returns bytes from its internal byte array or stores bytes into it. The bus signals are oversampled on a faster system clock, so the model can sit in a synthesizable test harness next to a flash controller under test.

The address space seen on the bus is 16 MiB, and addresses wrap modulo that size. Only the lowest `MEM_BYTES` bytes are backed by storage. A read above that range returns zero, and a program above it is dropped. A strap parameter turns the part into a ROM: program commands still run through their phases on the bus but change nothing. After reset every backed byte holds the erased value 0xFF.

Top module: `flash_spi_model`

## Requirements
- R1: After reset, and at any time while chip select is high, all four data output enables are low.
- R2: The command byte is taken on DQ0, most significant bit first, one bit per rising SCK edge. A byte that is not one of the fourteen listed commands makes the block drive nothing and store nothing until chip select rises.
- R3: Commands 0x03 (3-byte address) and 0x13 (4-byte address) are reads with no dummy clocks. Address bits arrive on DQ0. Data is driven on DQ1 alone, with enable mask 4'b0010, MSB first. Each bit is driven after a falling SCK edge, and the first one follows the falling edge that ends the last address clock.
- R4: Commands 0x0B (3-byte) and 0x0C (4-byte) read like R3 but insert exactly 8 dummy clocks after the address. No output is enabled during those clocks.
- R5: Commands 0x6B (3-byte) and 0x6C (4-byte) take a single-line address and 8 dummy clocks. Data is then driven as nibbles on DQ[3:0], with enable mask 4'b1111, high nibble first and DQ3 as the nibble MSB.
- R6: Commands 0xEB (3-byte) and 0xEC (4-byte) behave as R5, except that the address is also taken as nibbles on DQ[3:0], high nibble first.
- R7: Only the low 24 address bits are used, so the top byte of a 4-byte address is ignored. A read or program burst advances one byte per byte and wraps from 0xFFFFFF to 0x000000.
- R8: A read of an address at or above `MEM_BYTES` returns 0x00. A program to such an address changes nothing.
- R9: Program commands and their address and data lanes are: 0x02 (3-byte, single/single), 0x32 (3-byte, single/quad), 0x38 (3-byte, quad/quad), 0x12 (4-byte, single/single), 0x34 (4-byte, single/quad) and 0x3E (4-byte, quad/quad). Single-lane data is taken on DQ0. Each completed byte replaces the addressed byte. A partial byte at chip select rise is discarded.
- R10: With `READ_ONLY` set, program commands leave memory unchanged.
- R11: Raising chip select in any phase aborts the command, and the next command is decoded from a fresh start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the bus master, idle low |
| cs_n | input | 1 | Active-low chip select |
| dq_in | input | 4 | Values seen on the four data lines |
| dq_out | output | 4 | Values the model drives on the data lines |
| dq_oe | output | 4 | Per-line output enable |

## Verification
The bench aims at the first data bit after zero and after eight dummy clocks; a design off by one clock there returns every byte shifted by one bit or nibble. It reads across the backed/unbacked boundary and across the top of the 16 MiB space, where a design missing the zero fill or the 24-bit wrap returns stale or erased bytes. It programs into and past the end of the array, sends a 4-byte address whose top byte is not zero, aborts in the address phase and mid-byte, and sends an unknown opcode. A design that keeps partial bytes, misreads an aborted command or answers a bad opcode then corrupts a later readback. A second, read-only instance on the same bus must keep its erased contents through every program.

// File: rtl/flash_model_pkg.sv
// Shared types for the serial flash target model: command phases and
// the per-command descriptor produced by the opcode decoder.
package flash_model_pkg;

    typedef enum logic [2:0] {
        PH_CMD   = 3'd0,
        PH_ADDR  = 3'd1,
        PH_DUMMY = 3'd2,
        PH_RDATA = 3'd3,
        PH_WDATA = 3'd4,
        PH_SKIP  = 3'd5
    } phase_t;

    typedef struct packed {
        logic valid;      // opcode is one of the supported commands
        logic is_read;    // read (1) or program (0)
        logic addr4;      // four address bytes instead of three
        logic quad_addr;  // address taken as nibbles on all four lines
        logic quad_data;  // data moved as nibbles on all four lines
        logic fast;       // dummy clocks inserted before read data
    } cmd_desc_t;

endpackage

// File: rtl/flash_edge_detect.sv
// Oversamples the asynchronous bus pins on clk and reports SCK edges.
// Assumes SCK half-periods are several clk cycles long. The data lines
// and chip select pass through the same number of stages as SCK, so a
// reported edge lines up with the data seen at that edge.
module flash_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic [3:0] dq_in,
    output logic       sck_rise,
    output logic       sck_fall,
    output logic       cs_active,
    output logic [3:0] dq_s
);
    logic [STAGES:0]   sck_p;
    logic [STAGES-1:0] cs_p;
    logic [3:0]        dq_p [STAGES];

    // Shift pin samples through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p <= '0;
            cs_p  <= '1;
            for (int i = 0; i < STAGES; i++) dq_p[i] <= '0;
        end else begin
            sck_p <= {sck_p[STAGES-1:0], sck};
            cs_p  <= {cs_p[STAGES-2:0], cs_n};
            dq_p[0] <= dq_in;
            for (int i = 1; i < STAGES; i++) dq_p[i] <= dq_p[i-1];
        end
    end

    // Edge strobes and aligned outputs.
    assign sck_rise  = sck_p[STAGES-1] & ~sck_p[STAGES];
    assign sck_fall  = ~sck_p[STAGES-1] & sck_p[STAGES];
    assign cs_active = ~cs_p[STAGES-1];
    assign dq_s      = dq_p[STAGES-1];
endmodule

// File: rtl/flash_cmd_decode.sv
// Maps a command byte to its descriptor: read or program, address
// width, lanes for address and data, and whether dummy clocks follow.
// Unsupported bytes yield valid = 0. When the block is strapped
// read-only, program commands still decode so that they run on the bus.
module flash_cmd_decode
    import flash_model_pkg::*;
(
    input  logic [7:0] opcode,
    output cmd_desc_t  desc
);
    // Fixed command table.
    always_comb begin
        desc = '0;
        unique case (opcode)
            8'h03: desc = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
            8'h13: desc = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
            8'h0B: desc = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
            8'h0C: desc = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
            8'h6B: desc = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
            8'h6C: desc = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
            8'hEB: desc = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
            8'hEC: desc = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
            8'h02: desc = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
            8'h32: desc = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
            8'h38: desc = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
            8'h12: desc = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
            8'h34: desc = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
            8'h3E: desc = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
            default: desc = '0;
        endcase
    end
endmodule

// File: rtl/flash_mem_array.sv
// Backing byte store. It covers the low MEM_BYTES addresses of an
// ADDR_W-bit space. Reads outside it return zero and writes outside it
// are dropped. Reset fills every byte with ERASED.
module flash_mem_array #(
    parameter int         MEM_BYTES = 256,
    parameter int         ADDR_W    = 24,
    parameter logic [7:0] ERASED    = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data
);
    localparam int              IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(MEM_BYTES);

    logic [7:0] mem [MEM_BYTES];
    logic       rd_hit, wr_hit;

    assign rd_hit = {1'b0, rd_addr} < LIMIT;
    assign wr_hit = {1'b0, wr_addr} < LIMIT;

    // Erase on reset, otherwise store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= ERASED;
        end else if (we && wr_hit) begin
            mem[wr_addr[IDX_W-1:0]] <= wr_data;
        end
    end

    // Zero fill above the backed range.
    assign rd_data = rd_hit ? mem[rd_addr[IDX_W-1:0]] : 8'h00;
endmodule

// File: rtl/flash_spi_model.sv
// Serial NOR flash target. It sequences command, address, dummy and data
// phases from oversampled SCK edges. It samples on rising SCK and drives
// after falling SCK. Assumes mode-0 timing (SCK idle low) and SCK
// half-periods longer than SYNC_STAGES + 1 clk cycles.
module flash_spi_model
    import flash_model_pkg::*;
#(
    parameter int         MEM_BYTES    = 256,
    parameter bit         READ_ONLY    = 1'b0,
    parameter int         DUMMY_CYCLES = 8,
    parameter logic [7:0] ERASED_BYTE  = 8'hFF,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic [3:0] dq_in,
    output logic [3:0] dq_out,
    output logic [3:0] dq_oe
);
    localparam int ADDR_W  = 24;
    localparam int CNT_MAX = (DUMMY_CYCLES > 32) ? DUMMY_CYCLES : 32;
    localparam int CNT_W   = $clog2(CNT_MAX) + 1;

    logic             sck_rise, sck_fall, cs_active;
    logic [3:0]       dq_s;
    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       opcode;
    cmd_desc_t        dec, desc_q;
    logic [31:0]      addr_sh;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]       wr_shift;
    logic [2:0]       out_pos;
    logic [3:0]       dq_out_q;
    logic [7:0]       rd_data;
    logic             mem_we;

    logic [7:0]       op_next, wr_next;
    logic [31:0]      addr_next;
    logic [CNT_W-1:0] addr_last, wr_last;
    logic [2:0]       rd_last, bit_idx;

    flash_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .dq_in(dq_in),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_active(cs_active), .dq_s(dq_s)
    );

    flash_cmd_decode u_dec (.opcode(op_next), .desc(dec));

    flash_mem_array #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W), .ERASED(ERASED_BYTE)) u_mem (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr_q), .rd_data(rd_data),
        .we(mem_we), .wr_addr(addr_q), .wr_data(wr_next)
    );

    // Next shift values and per-command phase lengths.
    always_comb begin
        op_next   = {opcode[6:0], dq_s[0]};
        addr_next = desc_q.quad_addr ? {addr_sh[27:0], dq_s} : {addr_sh[30:0], dq_s[0]};
        wr_next   = desc_q.quad_data ? {wr_shift[3:0], dq_s} : {wr_shift[6:0], dq_s[0]};
        if (desc_q.addr4) addr_last = desc_q.quad_addr ? CNT_W'(7) : CNT_W'(31);
        else              addr_last = desc_q.quad_addr ? CNT_W'(5) : CNT_W'(23);
        wr_last   = desc_q.quad_data ? CNT_W'(1) : CNT_W'(7);
        rd_last   = desc_q.quad_data ? 3'd1 : 3'd7;
        bit_idx   = 3'd7 - out_pos;
    end

    // Byte store strobe at the last sampled group of each program byte.
    assign mem_we = (phase == PH_WDATA) && sck_rise && (cnt == wr_last)
                    && cs_active && !READ_ONLY;

    // Command phase sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            phase    <= PH_CMD;
            cnt      <= '0;
            opcode   <= '0;
            addr_sh  <= '0;
            out_pos  <= '0;
            wr_shift <= '0;
            dq_out_q <= '0;
            if (!rst_n) begin
                desc_q <= '0;
                addr_q <= '0;
            end
        end else begin
            unique case (phase)
                PH_CMD: if (sck_rise) begin
                    opcode <= op_next;
                    cnt    <= cnt + 1'b1;
                    if (cnt == CNT_W'(7)) begin
                        cnt <= '0;
                        if (dec.valid) begin
                            desc_q <= dec;
                            phase  <= PH_ADDR;
                        end else begin
                            phase  <= PH_SKIP;
                        end
                    end
                end
                PH_ADDR: if (sck_rise) begin
                    addr_sh <= addr_next;
                    cnt     <= cnt + 1'b1;
                    if (cnt == addr_last) begin
                        cnt     <= '0;
                        out_pos <= '0;
                        addr_q  <= addr_next[ADDR_W-1:0];
                        if (!desc_q.is_read)  phase <= PH_WDATA;
                        else if (desc_q.fast) phase <= PH_DUMMY;
                        else                  phase <= PH_RDATA;
                    end
                end
                PH_DUMMY: if (sck_rise) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(DUMMY_CYCLES - 1)) begin
                        cnt   <= '0;
                        phase <= PH_RDATA;
                    end
                end
                PH_RDATA: if (sck_fall) begin
                    if (desc_q.quad_data)
                        dq_out_q <= (out_pos == 3'd0) ? rd_data[7:4] : rd_data[3:0];
                    else
                        dq_out_q <= {2'b00, rd_data[bit_idx], 1'b0};
                    out_pos <= out_pos + 1'b1;
                    if (out_pos == rd_last) begin
                        out_pos <= '0;
                        addr_q  <= addr_q + 1'b1;
                    end
                end
                PH_WDATA: if (sck_rise) begin
                    wr_shift <= wr_next;
                    cnt      <= cnt + 1'b1;
                    if (cnt == wr_last) begin
                        cnt    <= '0;
                        addr_q <= addr_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Drive only during the data phase of reads.
    assign dq_out = dq_out_q;
    assign dq_oe  = (phase != PH_RDATA) ? 4'h0 : (desc_q.quad_data ? 4'hF : 4'h2);

    // Chip select release returns the sequencer to the command phase.
    assert_cs_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> phase == PH_CMD);
    // Only the two legal lane masks ever appear.
    assert_oe_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe == 4'h0 || dq_oe == 4'h2 || dq_oe == 4'hF);
    // Dummy run never exceeds its length.
    assert_dummy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_DUMMY |-> cnt < CNT_W'(DUMMY_CYCLES));
    // An unknown opcode parks the sequencer until deselect.
    assert_skip_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP && cs_active) |=> phase == PH_SKIP);
    // Read data phase belongs to a read command.
    assert_read_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_RDATA |-> desc_q.is_read);
    // Program data phase belongs to a program command.
    assert_write_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_WDATA |-> !desc_q.is_read);
endmodule

// File: tb/flash_spi_model_test.sv
// Scoreboard bench: a writable and a read-only instance share one bus.
module flash_spi_model_test;
    localparam int MEM  = 256;
    localparam int HALF = 4;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1;
    logic [3:0] dq_in = 4'h0;
    logic [3:0] dq_rw, oe_rw, dq_ro, oe_ro;

    int errors = 0, checks = 0;
    logic [7:0] ref_rw [MEM];
    logic [7:0] ref_ro [MEM];
    logic [7:0] data_buf [8];
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    flash_spi_model #(.MEM_BYTES(MEM), .READ_ONLY(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .dq_in(dq_in),
        .dq_out(dq_rw), .dq_oe(oe_rw));
    flash_spi_model #(.MEM_BYTES(MEM), .READ_ONLY(1'b1)) uut_ro (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .dq_in(dq_in),
        .dq_out(dq_ro), .dq_oe(oe_ro));

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop captured bytes and compare with the expected ones.
    initial forever begin
        @(negedge clk);
        while (got_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] g, e;
            string t;
            g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
            check(g === e, t, {24'h0, g}, {24'h0, e});
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    // Command table derived from the requirements.
    function automatic void op_info(input logic [7:0] op, output int ab, output bit qa,
                                    output bit qd, output bit fast);
        ab = 3; qa = 0; qd = 0; fast = 0;
        case (op)
            8'h13, 8'h12: ab = 4;
            8'h0B: fast = 1;
            8'h0C: begin ab = 4; fast = 1; end
            8'h6B: begin fast = 1; qd = 1; end
            8'h6C: begin ab = 4; fast = 1; qd = 1; end
            8'hEB: begin fast = 1; qd = 1; qa = 1; end
            8'hEC: begin ab = 4; fast = 1; qd = 1; qa = 1; end
            8'h32: qd = 1;
            8'h38: begin qd = 1; qa = 1; end
            8'h34: begin ab = 4; qd = 1; end
            8'h3E: begin ab = 4; qd = 1; qa = 1; end
            default: ;
        endcase
    endfunction

    // One SCK cycle: drive, sample in the low half, rise, fall.
    task automatic xfer(input logic [3:0] d, output logic [3:0] g_rw, output logic [3:0] g_ro,
                        output logic [3:0] o_rw, output logic [3:0] o_ro);
        dq_in = d;
        repeat (HALF) @(negedge clk);
        g_rw = dq_rw; g_ro = dq_ro; o_rw = oe_rw; o_ro = oe_ro;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int nbits, input bit quad);
        logic [3:0] a, b, c, e;
        int step;
        step = quad ? 4 : 1;
        for (int i = nbits - 1; i >= 0; i -= step)
            xfer(quad ? v[i -: 4] : {3'b000, v[i]}, a, b, c, e);
    endtask

    task automatic begin_cmd(input logic [7:0] op);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        send_bits({24'h0, op}, 8, 1'b0);
    endtask

    task automatic end_cmd;
        cs_n = 1'b1;
        dq_in = 4'h0;
        repeat (3 * HALF) @(negedge clk);
    endtask

    // Read n bytes, then cut extra groups before deselect.
    task automatic do_read(input logic [7:0] op, input logic [31:0] addr, input int n,
                           input int cut, input string tag);
        int ab; bit qa, qd, fast;
        logic [3:0] g_rw, g_ro, o_rw, o_ro;
        logic [7:0] acc_rw, acc_ro;
        bit oe_ok, dum_ok;
        op_info(op, ab, qa, qd, fast);
        begin_cmd(op);
        send_bits(addr, ab * 8, qa);
        dum_ok = 1;
        if (fast) begin
            for (int i = 0; i < 8; i++) begin
                xfer(4'h0, g_rw, g_ro, o_rw, o_ro);
                if (o_rw != 4'h0 || o_ro != 4'h0) dum_ok = 0;
            end
            check(dum_ok, {tag, " R4 dummy clocks undriven"}, {28'h0, o_rw}, 0);
        end
        oe_ok = 1;
        for (int b = 0; b < n; b++) begin
            logic [23:0] a;
            acc_rw = 0; acc_ro = 0;
            for (int g = 0; g < (qd ? 2 : 8); g++) begin
                xfer(4'h0, g_rw, g_ro, o_rw, o_ro);
                if (o_rw != (qd ? 4'hF : 4'h2) || o_ro != (qd ? 4'hF : 4'h2)) oe_ok = 0;
                acc_rw = qd ? {acc_rw[3:0], g_rw} : {acc_rw[6:0], g_rw[1]};
                acc_ro = qd ? {acc_ro[3:0], g_ro} : {acc_ro[6:0], g_ro[1]};
            end
            a = addr[23:0] + 24'(b);
            exp_q.push_back(a < MEM ? ref_rw[a] : 8'h00); got_q.push_back(acc_rw);
            tag_q.push_back({tag, " data"});
            exp_q.push_back(a < MEM ? ref_ro[a] : 8'h00); got_q.push_back(acc_ro);
            tag_q.push_back({tag, " R10 read-only data"});
        end
        for (int g = 0; g < cut; g++) xfer(4'h0, g_rw, g_ro, o_rw, o_ro);
        check(oe_ok, {tag, " lane enable mask"}, {28'h0, o_rw}, qd ? 32'hF : 32'h2);
        end_cmd();
    endtask

    // Program n bytes from data_buf, then send extra partial groups.
    task automatic do_prog(input logic [7:0] op, input logic [31:0] addr, input int n,
                           input int extra);
        int ab; bit qa, qd, fast;
        op_info(op, ab, qa, qd, fast);
        begin_cmd(op);
        send_bits(addr, ab * 8, qa);
        for (int b = 0; b < n; b++) begin
            logic [23:0] a;
            send_bits({24'h0, data_buf[b]}, 8, qd);
            a = addr[23:0] + 24'(b);
            if (a < MEM) ref_rw[a] = data_buf[b];
        end
        send_bits(32'hFFFF_FFFF, extra, qd);
        end_cmd();
    endtask

    task automatic fill(input logic [7:0] k);
        logic [7:0] base [8];
        base = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h96, 8'h69, 8'hE1, 8'h1E};
        for (int i = 0; i < 8; i++) data_buf[i] = base[i] ^ k;
    endtask

    initial begin
        for (int i = 0; i < MEM; i++) begin ref_rw[i] = 8'hFF; ref_ro[i] = 8'hFF; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(oe_rw == 4'h0 && oe_ro == 4'h0, "R1 enables low after reset", {28'h0, oe_rw}, 0);

        fill(8'h00); do_prog(8'h02, 32'h10, 8, 0);
        do_read(8'h03, 32'h10, 10, 0, "R3 R9 op03/op02");
        fill(8'h11); do_prog(8'h32, 32'h20, 8, 0);
        do_read(8'h13, 32'h20, 8, 0, "R3 R9 op13/op32");
        fill(8'h22); do_prog(8'h38, 32'h30, 8, 0);
        do_read(8'h0B, 32'h2C, 8, 0, "R4 R9 op0B/op38");
        fill(8'h33); do_prog(8'h12, 32'h40, 8, 0);
        do_read(8'h0C, 32'hAB00_0040, 8, 0, "R7 R4 op0C high byte ignored");
        fill(8'h44); do_prog(8'h34, 32'h50, 8, 0);
        do_read(8'h6B, 32'h50, 8, 0, "R5 R9 op6B/op34");
        fill(8'h55); do_prog(8'h3E, 32'h5A00_0060, 8, 0);
        do_read(8'h6C, 32'h60, 8, 0, "R5 op6C");
        do_read(8'hEB, 32'h5C, 8, 0, "R6 opEB");
        do_read(8'hEC, 32'h1200_0064, 4, 0, "R6 opEC");

        fill(8'h66); do_prog(8'h02, 32'hFE, 4, 0);
        do_read(8'h03, 32'hFC, 8, 0, "R8 unbacked boundary");
        fill(8'h77); do_prog(8'h02, 32'hFF_FFFF, 2, 0);
        do_read(8'h0B, 32'hFF_FFFE, 4, 0, "R7 wrap at top of space");

        // R2: unknown opcode with busy data lines must drive and store nothing.
        begin
            logic [3:0] a, b, c, e;
            bit quiet;
            quiet = 1;
            begin_cmd(8'h5A);
            for (int i = 0; i < 40; i++) begin
                xfer(4'hF, a, b, c, e);
                if (c != 4'h0 || e != 4'h0) quiet = 0;
            end
            end_cmd();
            check(quiet, "R2 unknown opcode drives nothing", {28'h0, c}, 0);
        end
        do_read(8'h03, 32'h0, 4, 0, "R2 memory unchanged after unknown opcode");

        // R11: abort inside address phase, then a fresh command works.
        begin_cmd(8'h02);
        send_bits(32'h0, 12, 1'b0);
        end_cmd();
        do_read(8'h03, 32'h10, 3, 0, "R11 abort in address phase");
        // R11: abort mid-byte of a read, then read elsewhere.
        do_read(8'h6B, 32'h20, 1, 1, "R11 abort mid read");
        do_read(8'h03, 32'h30, 2, 0, "R11 fresh read after abort");
        // R9: partial byte at deselect is dropped.
        fill(8'h88); do_prog(8'h02, 32'h80, 1, 4);
        do_read(8'h03, 32'h80, 2, 0, "R9 partial byte discarded");

        repeat (20) @(negedge clk);
        check(got_q.size() == 0, "R3 scoreboard drained", got_q.size(), 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule